// File: doc/BRIEF.md
# Two-Beat Burst Synchronous SRAM with Shared Data Bus

This block is a synthesizable model of a pipelined synchronous SRAM. Every transaction moves a fixed pair of 18-bit words over a data path that is shared by reads and writes. The design runs on a single beat clock. An internal half-period phase splits each command period into two beats. Commands are taken only on the first beat of a period. Each data beat, in either direction, takes up one beat clock.

Writes are posted. The two data beats land in a one-transaction buffer and go into the storage array only when the next write finishes its capture. A read that touches a pending word gets the newest bytes, overlaid on the array contents wherever a byte was masked. The data path has three parts: an input `dq_in`, an output `dq_out` and a drive-enable `dq_oe`. `dq_oe` stands in for the tri-state control of a common bus. A write that would collide with the output beats of an earlier read is refused and flagged.

Top module: `b2sr_top`

## Requirements
- R1: `half_phase` low at a rising edge marks a command edge. At a command edge, `load_n` low starts a transaction. `load_n` high makes a no-operation that changes neither the storage nor the outputs.
- R2: At a command edge `rd_wr` high selects a read and `rd_wr` low selects a write.
- R3: The first word of a burst uses `cmd_addr`. The second uses `cmd_addr` with bit 0 inverted, so the burst wraps inside the aligned pair.
- R4: For a write accepted at command edge E, the first data beat is sampled at edge E+1 and the second at E+2.
- R5: `byte_we_n` is active low and is sampled with each data beat. Bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. A high bit leaves that byte unchanged.
- R6: A new command is accepted at every command edge with no idle period. Two reads on consecutive command edges give four back-to-back output beats.
- R7: Writes are posted. A read always returns the newest written bytes, merged with the older contents for masked bytes, whether or not the write has reached the array.
- R8: For a read at command edge E, `dq_out` carries the first word from edge E+3 and the second word from edge E+4. `dq_oe` is high for exactly those two beats.
- R9: A write issued one or two command periods after a read is refused. `bus_err` is high for the command period that follows it, and `dq_oe` is never high while write data is expected.
- R10: Reset clears the storage and the posted buffer and holds `dq_oe`, `bus_err` and `half_phase` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock; two beats form one command period |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low transaction start, sampled at command edges |
| rd_wr | input | 1 | High for read, low for write |
| cmd_addr | input | 6 | Word address of the first beat |
| dq_in | input | 18 | Write data beat |
| byte_we_n | input | 2 | Active-low byte write enables per data beat |
| dq_out | output | 18 | Read data beat |
| dq_oe | output | 1 | High while the block drives read data |
| bus_err | output | 1 | High for one command period after a refused write |
| half_phase | output | 1 | Low when the next rising edge is a command edge |

## Verification
The vector table runs writes with full masks, single-byte masks and all bytes masked, followed by reads at even and odd addresses. This separates burst wrap order from plain increment, and separates byte merging from whole-word replacement. Some reads hit the pending buffer and others hit words already committed, so a design that forgets the posted data gives different values from one that merges it. Directed sequences cover four cases. A read placed on the edge right after a write's capture exposes a late merge. Consecutive reads check that the output beats run without a gap. Writes at two, four and six beats after a read mark the edge of the refusal window. A reset taken while a write is still pending shows whether the buffer is cleared.

// File: rtl/b2sr_pkg.sv
package b2sr_pkg;
  localparam int B2_ADDR_W = 6;
  localparam int B2_WORD_W = 18;
  localparam int B2_BYTE_N = 2;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_RD,
    CMD_WR,
    CMD_REFUSE
  } cmd_kind_e;
endpackage

// File: rtl/b2sr_cmd_ctrl.sv
module b2sr_cmd_ctrl
  import b2sr_pkg::*;
#(
  parameter int ADDR_W = B2_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              phase,
  output logic              rd_beat0,
  output logic              rd_beat1,
  output logic [ADDR_W-1:0] rd_base_addr,
  output logic              wexp0,
  output logic              wexp1,
  output logic [ADDR_W-1:0] wr_base_addr,
  output logic              err
);
  // edges from read command to first output beat (1.5 command periods)
  localparam int RD_LAT = 3;
  // command periods after a read during which a write would clash
  localparam int GUARD  = (RD_LAT + 1) / 2;

  cmd_kind_e         kind;
  logic              cmd_edge;
  logic [GUARD-1:0]  rd_hist;
  logic [RD_LAT:0]   rd_pipe;
  logic [ADDR_W-1:0] ra_pipe [RD_LAT];

  assign cmd_edge = ~phase;

  always_comb begin
    if (load_n)        kind = CMD_IDLE;
    else if (rd_wr)    kind = CMD_RD;
    else if (|rd_hist) kind = CMD_REFUSE;
    else               kind = CMD_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= 1'b0;
      rd_hist      <= '0;
      rd_pipe      <= '0;
      wexp0        <= 1'b0;
      wexp1        <= 1'b0;
      err          <= 1'b0;
      wr_base_addr <= '0;
      for (int i = 0; i < RD_LAT; i++) ra_pipe[i] <= '0;
    end else begin
      phase      <= ~phase;
      rd_pipe    <= {rd_pipe[RD_LAT-1:0], cmd_edge && (kind == CMD_RD)};
      ra_pipe[0] <= cmd_addr;
      for (int i = 1; i < RD_LAT; i++) ra_pipe[i] <= ra_pipe[i-1];
      wexp0 <= cmd_edge && (kind == CMD_WR);
      wexp1 <= wexp0;
      if (cmd_edge) begin
        rd_hist <= {rd_hist[GUARD-2:0], kind == CMD_RD};
        err     <= (kind == CMD_REFUSE);
        if (kind == CMD_WR) wr_base_addr <= cmd_addr;
      end
    end
  end

  assign rd_beat0     = rd_pipe[RD_LAT-1];
  assign rd_beat1     = rd_pipe[RD_LAT];
  assign rd_base_addr = ra_pipe[RD_LAT-1];

  // R1: an idle command edge starts neither a write window nor a read
  assert_idle_no_action_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_edge && load_n) |=> (!wexp0 && !rd_pipe[0]));

  // R9: a refused write raises the flag and opens no capture window
  assert_refuse_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_edge && kind == CMD_REFUSE) |=> (err && !wexp0));
endmodule

// File: rtl/b2sr_write_post.sv
module b2sr_write_post
  import b2sr_pkg::*;
#(
  parameter int ADDR_W = B2_ADDR_W,
  parameter int WORD_W = B2_WORD_W,
  parameter int BYTE_N = B2_BYTE_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wexp0,
  input  logic              wexp1,
  input  logic [ADDR_W-1:0] wr_base_addr,
  input  logic [WORD_W-1:0] dq_in,
  input  logic [BYTE_N-1:0] byte_we_n,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [WORD_W-1:0] pend_word0,
  output logic [BYTE_N-1:0] pend_en0,
  output logic [WORD_W-1:0] pend_word1,
  output logic [BYTE_N-1:0] pend_en1,
  output logic              commit_go
);
  logic [WORD_W-1:0] st_word;
  logic [BYTE_N-1:0] st_en;

  // older posted entry retires when a newer write finishes its capture
  assign commit_go = wexp1 && pend_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_word    <= '0;
      st_en      <= '0;
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_word0 <= '0;
      pend_en0   <= '0;
      pend_word1 <= '0;
      pend_en1   <= '0;
    end else begin
      if (wexp0) begin
        st_word <= dq_in;
        st_en   <= ~byte_we_n;
      end
      if (wexp1) begin
        pend_valid <= 1'b1;
        pend_addr  <= wr_base_addr;
        pend_word0 <= st_word;
        pend_en0   <= st_en;
        pend_word1 <= dq_in;
        pend_en1   <= ~byte_we_n;
      end
    end
  end

  // R4: second beat capture always follows a first beat capture
  assert_window_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wexp1 |-> $past(wexp0));

  // R7: a posted entry stays put until the next write completes
  assert_pend_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !wexp1) |=> ($stable(pend_addr) && $stable(pend_word0) && $stable(pend_word1)));
endmodule

// File: rtl/b2sr_core.sv
module b2sr_core
  import b2sr_pkg::*;
#(
  parameter int ADDR_W = B2_ADDR_W,
  parameter int WORD_W = B2_WORD_W,
  parameter int BYTE_N = B2_BYTE_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_go,
  input  logic              pend_valid,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [WORD_W-1:0] pend_word0,
  input  logic [BYTE_N-1:0] pend_en0,
  input  logic [WORD_W-1:0] pend_word1,
  input  logic [BYTE_N-1:0] pend_en1,
  input  logic              rd_beat0,
  input  logic              rd_beat1,
  input  logic [ADDR_W-1:0] rd_base_addr,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BYTE_W = WORD_W / BYTE_N;

  function automatic logic [ADDR_W-1:0] pair_mate(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], ~a[0]};
  endfunction

  function automatic logic [WORD_W-1:0] byte_merge(input logic [WORD_W-1:0] older,
                                                   input logic [WORD_W-1:0] newer,
                                                   input logic [BYTE_N-1:0] en);
    logic [WORD_W-1:0] r;
    r = older;
    for (int b = 0; b < BYTE_N; b++)
      if (en[b]) r[b*BYTE_W +: BYTE_W] = newer[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] out_base;
  logic [ADDR_W-1:0] rd_sel_addr;
  logic [WORD_W-1:0] coh_word;
  logic              hit0;
  logic              hit1;

  assign rd_sel_addr = rd_beat0 ? rd_base_addr : pair_mate(out_base);
  assign hit0        = pend_valid && (pend_addr == rd_sel_addr);
  assign hit1        = pend_valid && (pair_mate(pend_addr) == rd_sel_addr);

  always_comb begin
    coh_word = mem[rd_sel_addr];
    if (hit0) coh_word = byte_merge(coh_word, pend_word0, pend_en0);
    if (hit1) coh_word = byte_merge(coh_word, pend_word1, pend_en1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      out_base <= '0;
    end else begin
      if (commit_go) begin
        mem[pend_addr]            <= byte_merge(mem[pend_addr], pend_word0, pend_en0);
        mem[pair_mate(pend_addr)] <= byte_merge(mem[pair_mate(pend_addr)], pend_word1, pend_en1);
      end
      dq_oe <= rd_beat0 || rd_beat1;
      if (rd_beat0 || rd_beat1) dq_out <= coh_word;
      if (rd_beat0) out_base <= rd_base_addr;
    end
  end

  // R8: every first read beat is followed by its second beat
  assert_beat_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat0 |=> rd_beat1);

  // R6: the two beats of one read and the next read never fire together
  assert_one_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_beat0, rd_beat1}));
endmodule

// File: rtl/b2sr_top.sv
module b2sr_top
  import b2sr_pkg::*;
#(
  parameter int ADDR_W = B2_ADDR_W,
  parameter int WORD_W = B2_WORD_W,
  parameter int BYTE_N = B2_BYTE_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] dq_in,
  input  logic [BYTE_N-1:0] byte_we_n,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              bus_err,
  output logic              half_phase
);
  logic              rd_beat0, rd_beat1;
  logic [ADDR_W-1:0] rd_base_addr, wr_base_addr, pend_addr;
  logic              wexp0, wexp1;
  logic              pend_valid, commit_go;
  logic [WORD_W-1:0] pend_word0, pend_word1;
  logic [BYTE_N-1:0] pend_en0, pend_en1;

  b2sr_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr(rd_wr), .cmd_addr(cmd_addr),
    .phase(half_phase), .rd_beat0(rd_beat0), .rd_beat1(rd_beat1),
    .rd_base_addr(rd_base_addr), .wexp0(wexp0), .wexp1(wexp1),
    .wr_base_addr(wr_base_addr), .err(bus_err)
  );

  b2sr_write_post #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_N(BYTE_N)) u_post (
    .clk(clk), .rst_n(rst_n), .wexp0(wexp0), .wexp1(wexp1),
    .wr_base_addr(wr_base_addr), .dq_in(dq_in), .byte_we_n(byte_we_n),
    .pend_valid(pend_valid), .pend_addr(pend_addr),
    .pend_word0(pend_word0), .pend_en0(pend_en0),
    .pend_word1(pend_word1), .pend_en1(pend_en1), .commit_go(commit_go)
  );

  b2sr_core #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_N(BYTE_N)) u_core (
    .clk(clk), .rst_n(rst_n), .commit_go(commit_go), .pend_valid(pend_valid),
    .pend_addr(pend_addr), .pend_word0(pend_word0), .pend_en0(pend_en0),
    .pend_word1(pend_word1), .pend_en1(pend_en1),
    .rd_beat0(rd_beat0), .rd_beat1(rd_beat1), .rd_base_addr(rd_base_addr),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // R8: a read command drives exactly the fourth and fifth beats after it
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_phase && !load_n && rd_wr) |-> ##4 dq_oe ##1 dq_oe);

  // R9: output drive and expected write data never share the bus
  assert_no_bus_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && (wexp0 || wexp1)));
endmodule

// File: tb/b2sr_top_tb.sv
module b2sr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic        rd_wr = 1'b0;
  logic [5:0]  cmd_addr = '0;
  logic [17:0] dq_in = '0;
  logic [1:0]  byte_we_n = 2'b11;
  logic [17:0] dq_out;
  logic        dq_oe;
  logic        bus_err;
  logic        half_phase;

  int n_tests = 0;
  int n_fail  = 0;

  b2sr_top u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .rd_wr(rd_wr), .cmd_addr(cmd_addr),
    .dq_in(dq_in), .byte_we_n(byte_we_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .bus_err(bus_err), .half_phase(half_phase)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;   // 0 idle, 1 write, 2 read
    logic [5:0]  a;
    logic [17:0] d0;
    logic [17:0] d1;
    logic [1:0]  m0;
    logic [1:0]  m1;
    logic [17:0] e0;
    logic [17:0] e1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 6'd4,  18'h12345, 18'h0ABCD, 2'b00, 2'b00, 18'h00000, 18'h00000},
    '{2'd2, 6'd4,  18'h00000, 18'h00000, 2'b11, 2'b11, 18'h12345, 18'h0ABCD},
    '{2'd2, 6'd5,  18'h00000, 18'h00000, 2'b11, 2'b11, 18'h0ABCD, 18'h12345},
    '{2'd1, 6'd5,  18'h3FFFF, 18'h00000, 2'b01, 2'b10, 18'h00000, 18'h00000},
    '{2'd2, 6'd4,  18'h00000, 18'h00000, 2'b11, 2'b11, 18'h12200, 18'h3FFCD},
    '{2'd1, 6'd9,  18'h00001, 18'h20000, 2'b00, 2'b00, 18'h00000, 18'h00000},
    '{2'd2, 6'd8,  18'h00000, 18'h00000, 2'b11, 2'b11, 18'h20000, 18'h00001},
    '{2'd2, 6'd5,  18'h00000, 18'h00000, 2'b11, 2'b11, 18'h3FFCD, 18'h12200},
    '{2'd0, 6'd4,  18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00, 18'h00000, 18'h00000},
    '{2'd2, 6'd4,  18'h00000, 18'h00000, 2'b11, 2'b11, 18'h12200, 18'h3FFCD},
    '{2'd2, 6'd20, 18'h00000, 18'h00000, 2'b11, 2'b11, 18'h00000, 18'h00000},
    '{2'd1, 6'd21, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b11, 18'h00000, 18'h00000},
    '{2'd2, 6'd20, 18'h00000, 18'h00000, 2'b11, 2'b11, 18'h00000, 18'h00000}
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_slot();
    @(negedge clk);
    while (half_phase) @(negedge clk);
  endtask

  task automatic idle_bus();
    load_n = 1'b1; rd_wr = 1'b0; dq_in = '0; byte_we_n = 2'b11;
  endtask

  // command plus two data beats; ld selects a real write or an idle slot
  task automatic do_write(input logic ld, input logic [5:0] a, input logic [17:0] d0,
                          input logic [17:0] d1, input logic [1:0] m0, input logic [1:0] m1);
    wait_slot();
    load_n = ld; rd_wr = 1'b0; cmd_addr = a;
    @(negedge clk); load_n = 1'b1; dq_in = d0; byte_we_n = m0;
    @(negedge clk); dq_in = d1; byte_we_n = m1;
    @(negedge clk); idle_bus();
  endtask

  task automatic do_read(input logic [5:0] a, input logic [17:0] e0, input logic [17:0] e1,
                         input string tag);
    wait_slot();
    load_n = 1'b0; rd_wr = 1'b1; cmd_addr = a;
    @(negedge clk); idle_bus();
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R8 oe beat0"}, {17'd0, dq_oe}, 18'd1);
    chk({tag, " beat0"}, dq_out, e0);
    @(negedge clk);
    chk({tag, " R8 oe beat1"}, {17'd0, dq_oe}, 18'd1);
    chk({tag, " beat1"}, dq_out, e1);
    @(negedge clk);
    chk({tag, " R8 oe off"}, {17'd0, dq_oe}, 18'd0);
    chk({tag, " R9 no err"}, {17'd0, bus_err}, 18'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset oe", {17'd0, dq_oe}, 18'd0);
    chk("R10 reset err", {17'd0, bus_err}, 18'd0);
    chk("R10 reset phase", {17'd0, half_phase}, 18'd0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd1: do_write(1'b0, VECS[i].a, VECS[i].d0, VECS[i].d1, VECS[i].m0, VECS[i].m1);
        2'd2: do_read(VECS[i].a, VECS[i].e0, VECS[i].e1, $sformatf("R2/R3/R5/R7 vec%0d", i));
        default: begin
          do_write(1'b1, VECS[i].a, VECS[i].d0, VECS[i].d1, VECS[i].m0, VECS[i].m1);
          chk("R1 idle no drive", {17'd0, dq_oe}, 18'd0);
        end
      endcase
    end

    // R7 R4: read issued on the edge that takes the second write beat
    wait_slot();
    load_n = 1'b0; rd_wr = 1'b0; cmd_addr = 6'd12;
    @(negedge clk); load_n = 1'b1; dq_in = 18'h11111; byte_we_n = 2'b00;
    @(negedge clk); load_n = 1'b0; rd_wr = 1'b1; cmd_addr = 6'd12; dq_in = 18'h22222;
    @(negedge clk); idle_bus();
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R7 tight read beat0", dq_out, 18'h11111);
    @(negedge clk);
    chk("R7 tight read beat1", dq_out, 18'h22222);
    @(negedge clk);

    // R6: reads on consecutive command edges
    wait_slot();
    load_n = 1'b0; rd_wr = 1'b1; cmd_addr = 6'd4;
    @(negedge clk); load_n = 1'b1;
    @(negedge clk); load_n = 1'b0; rd_wr = 1'b1; cmd_addr = 6'd8;
    @(negedge clk); idle_bus();
    @(negedge clk);
    chk("R6 b2b first beat0", dq_out, 18'h12200);
    @(negedge clk);
    chk("R6 b2b first beat1", dq_out, 18'h3FFCD);
    @(negedge clk);
    chk("R6 b2b oe continuous", {17'd0, dq_oe}, 18'd1);
    chk("R6 b2b second beat0", dq_out, 18'h20000);
    @(negedge clk);
    chk("R6 b2b second beat1", dq_out, 18'h00001);
    @(negedge clk);
    chk("R6 b2b oe off", {17'd0, dq_oe}, 18'd0);

    // R9: write one period after a read is refused
    wait_slot();
    load_n = 1'b0; rd_wr = 1'b1; cmd_addr = 6'd4;
    @(negedge clk); load_n = 1'b1;
    @(negedge clk); load_n = 1'b0; rd_wr = 1'b0; cmd_addr = 6'd12;
    @(negedge clk); load_n = 1'b1; dq_in = 18'h3FFFF; byte_we_n = 2'b00;
    chk("R9 err near write", {17'd0, bus_err}, 18'd1);
    @(negedge clk);
    chk("R9 read beat0 kept", dq_out, 18'h12200);
    @(negedge clk); idle_bus();
    chk("R9 err clears", {17'd0, bus_err}, 18'd0);
    chk("R9 read beat1 kept", dq_out, 18'h3FFCD);
    @(negedge clk);

    // R9: write two periods after is refused, three periods after is taken
    wait_slot();
    load_n = 1'b0; rd_wr = 1'b1; cmd_addr = 6'd20;
    @(negedge clk); load_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); load_n = 1'b0; rd_wr = 1'b0; cmd_addr = 6'd12;
    @(negedge clk); load_n = 1'b1;
    chk("R9 err far write", {17'd0, bus_err}, 18'd1);
    @(negedge clk); load_n = 1'b0; rd_wr = 1'b0; cmd_addr = 6'd13;
    @(negedge clk); load_n = 1'b1; dq_in = 18'h00AAA; byte_we_n = 2'b00;
    chk("R9 boundary write taken", {17'd0, bus_err}, 18'd0);
    @(negedge clk); dq_in = 18'h00BBB;
    @(negedge clk); idle_bus();
    do_read(6'd12, 18'h00BBB, 18'h00AAA, "R9 refused writes dropped");

    // R10: reset drops a pending write
    do_write(1'b0, 6'd30, 18'h15555, 18'h2AAAA, 2'b00, 2'b00);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid reset oe", {17'd0, dq_oe}, 18'd0);
    chk("R10 mid reset phase", {17'd0, half_phase}, 18'd0);
    rst_n = 1'b1;
    do_read(6'd30, 18'h00000, 18'h00000, "R10 pending cleared");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule